// File: doc/BRIEF.md
# Dual-Mode Interrupt Request Generator

This block produces an active-low interrupt request for a bus-controller or remote-terminal device. Event strobes from two groups of sources land in two sticky status registers. Each status register has its own mask register. A status bit can only raise a request when its mask bit is set, although the status bit itself records every event.

A configuration bit chooses the output style. In pulse style, each enabled event gives one low pulse of about 500 ns. The pulse width is counted in core clocks and scaled by a clock-rate select. In level style, the output goes low and stays low until the host clears it. The host clears it either by writing an interrupt-reset command, or, when auto-clear is on, by reading the status registers that hold enabled pending bits. The host reaches the registers through a simple write/read strobe port with registered read data.

Top module: `irq_gen`

## Requirements
- R1: While `rst_ni` is low and after it is released, `irq_no` is 1 and both status registers read 0. The config register (address 0) reads 0, which means pulse style with auto-clear off. Both mask registers read 0.
- R2: Each event bit sets its status bit on the clock edge where it is sampled high, whether or not the bit is masked. Status register A is at address 4 (fed by `evt_a_i`) and status register B is at address 5 (fed by `evt_b_i`). Read data appears on `rdata_o` one cycle after the read strobe.
- R3: An event whose mask bit is 0 never drives `irq_no` low. Mask A is at address 2 and mask B is at address 3.
- R4: In pulse style (config bit 0 = 0), an enabled event on edge E drives `irq_no` low for exactly N cycles starting at E. N is 5, 6, 8 or 10 for `clk_sel_i` = 0, 1, 2 or 3 (10, 12, 16 or 20 MHz).
- R5: An enabled event that arrives during a pulse neither stretches nor shortens that pulse. It causes one further full pulse after the output has been high for exactly one cycle.
- R6: In level style (config bit 0 = 1), an enabled event drives `irq_no` low on the next edge. The output then stays low until one of the clear conditions of R7 or R9 occurs.
- R7: Writing a value with bit 0 set to address 1 (the command register) returns a held level to high. It also zeroes both status registers.
- R8: With auto-clear off (config bit 1 = 0), reading a status register leaves its content and the held level unchanged.
- R9: With auto-clear on (config bit 1 = 1), reading a status register returns its content and then zeroes it. The level releases on that read edge once no enabled pending bit remains.
- R10: When both status registers hold enabled pending bits, reading only one of them keeps `irq_no` low. Reading the second one releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low master clear |
| clk_sel_i | input | 2 | Core clock rate: 0=10, 1=12, 2=16, 3=20 MHz |
| evt_a_i | input | W | Event strobes for status register A |
| evt_b_i | input | W | Event strobes for status register B |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Registered read data |
| irq_no | output | 1 | Active-low interrupt request |

## Verification
The pulse-width property assumes that `clk_sel_i` and the style bit stay fixed while a pulse is in flight. The bench only changes them when the output has been high and idle. The hold property assumes that the only ways to release a held level are a command write, an auto-clear status read or a config write. The bench therefore issues no other register traffic while checking a held level. Events are one-cycle strobes. The bench never raises an event in the same cycle as a clear command, so the expected status after a clear is unambiguous.

// File: rtl/irq_gen_pkg.sv
package irq_gen_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CFG   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMD   = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT0 = 3'd4;

  localparam int unsigned CFG_LEVEL_BIT = 0;
  localparam int unsigned CFG_AUTO_BIT  = 1;
  localparam int unsigned CMD_CLR_BIT   = 0;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_PULSE = 2'd1,
    PS_GAP   = 2'd2
  } pulse_state_e;

  function automatic int unsigned clk_mhz(input logic [1:0] sel);
    case (sel)
      2'd0:    return 10;
      2'd1:    return 12;
      2'd2:    return 16;
      default: return 20;
    endcase
  endfunction

  // pulse length in core cycles for a given clock select
  function automatic int unsigned pulse_cycles(input logic [1:0] sel, input int unsigned ns);
    return (ns * clk_mhz(sel)) / 1000;
  endfunction
endpackage

// File: rtl/irq_stat_reg.sv
module irq_stat_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         mask_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_clr_i,
  input  logic         clr_all_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         pend_next_o
);
  logic [W-1:0] stat_q, stat_n, mask_q;

  // events win over any clear in the same cycle
  always_comb begin
    stat_n = stat_q;
    if (clr_all_i || rd_clr_i) stat_n = '0;
    stat_n = stat_n | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_n;
      if (mask_wr_i) mask_q <= wdata_i;
    end
  end

  assign stat_o      = stat_q;
  assign mask_o      = mask_q;
  assign pend_next_o = |(stat_n & mask_q);
endmodule

// File: rtl/irq_pulse_fsm.sv
module irq_pulse_fsm
  import irq_gen_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          trig_i,
  input  logic [CW-1:0] width_i,
  output logic          low_o
);
  pulse_state_e  state_q;
  logic [CW-1:0] cnt_q;
  logic          req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_IDLE;
      cnt_q   <= '0;
      req_q   <= 1'b0;
    end else if (!en_i) begin
      state_q <= PS_IDLE;
      cnt_q   <= '0;
      req_q   <= 1'b0;
    end else begin
      case (state_q)
        PS_IDLE: if (trig_i) begin
          state_q <= PS_PULSE;
          cnt_q   <= width_i - 1'b1;
        end
        PS_PULSE: begin
          if (trig_i) req_q <= 1'b1;  // one queued follow-up pulse
          if (cnt_q == '0) state_q <= PS_GAP;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        PS_GAP: begin
          if (trig_i || req_q) begin
            state_q <= PS_PULSE;
            cnt_q   <= width_i - 1'b1;
            req_q   <= 1'b0;
          end else begin
            state_q <= PS_IDLE;
          end
        end
        default: state_q <= PS_IDLE;
      endcase
    end
  end

  assign low_o = (state_q == PS_PULSE);
endmodule

// File: rtl/irq_level_ctl.sv
module irq_level_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic clr_i,
  output logic low_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lvl_q <= 1'b0;
    else if (!en_i)   lvl_q <= 1'b0;
    else if (set_i)   lvl_q <= 1'b1;
    else if (clr_i)   lvl_q <= 1'b0;
  end

  assign low_o = lvl_q;
endmodule

// File: rtl/irq_gen.sv
module irq_gen
  import irq_gen_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned PULSE_NS = 500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        clk_sel_i,
  input  logic [W-1:0]      evt_a_i,
  input  logic [W-1:0]      evt_b_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic              irq_no
);
  localparam int unsigned NREG   = 2;
  localparam int unsigned MAX_PW = pulse_cycles(2'd3, PULSE_NS);
  localparam int unsigned CW     = $clog2(MAX_PW + 1);

  logic [W-1:0]  cfg_q;
  logic          cfg_level_q, cfg_auto_q;
  logic          wr_cfg, cmd_clr;
  logic [W-1:0]  evt_v  [NREG];
  logic [W-1:0]  stat_q [NREG];
  logic [W-1:0]  mask_q [NREG];
  logic [NREG-1:0] rd_stat, pend_n, evt_en;
  logic          new_evt, lvl_clr, pulse_low, level_low;
  logic [CW-1:0] width;
  logic [W-1:0]  rdata_q;

  assign cfg_level_q = cfg_q[CFG_LEVEL_BIT];
  assign cfg_auto_q  = cfg_q[CFG_AUTO_BIT];
  assign wr_cfg  = wr_en_i && (addr_i == A_CFG);
  assign cmd_clr = wr_en_i && (addr_i == A_CMD) && wdata_i[CMD_CLR_BIT];
  assign evt_v[0] = evt_a_i;
  assign evt_v[1] = evt_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (wr_cfg) cfg_q <= wdata_i;
  end

  for (genvar k = 0; k < NREG; k++) begin : g_stat
    assign rd_stat[k] = rd_en_i && (addr_i == A_STAT0 + ADDR_W'(k));
    assign evt_en[k]  = |(evt_v[k] & mask_q[k]);
    irq_stat_reg #(.W(W)) u_stat (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .evt_i       (evt_v[k]),
      .mask_wr_i   (wr_en_i && (addr_i == A_MASK0 + ADDR_W'(k))),
      .wdata_i     (wdata_i),
      .rd_clr_i    (rd_stat[k] && cfg_auto_q),
      .clr_all_i   (cmd_clr),
      .stat_o      (stat_q[k]),
      .mask_o      (mask_q[k]),
      .pend_next_o (pend_n[k])
    );
  end

  assign new_evt = |evt_en;
  // auto-clear releases only when no enabled bit survives the read
  assign lvl_clr = cmd_clr || (cfg_auto_q && (|rd_stat) && !(|pend_n));

  always_comb begin
    width = CW'(pulse_cycles(clk_sel_i, PULSE_NS));
  end

  irq_pulse_fsm #(.CW(CW)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (!cfg_level_q),
    .trig_i  (new_evt),
    .width_i (width),
    .low_o   (pulse_low)
  );

  irq_level_ctl u_level (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_level_q),
    .set_i  (new_evt),
    .clr_i  (lvl_clr),
    .low_o  (level_low)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_en_i) begin
      case (addr_i)
        A_CFG:                rdata_q <= cfg_q;
        A_MASK0:              rdata_q <= mask_q[0];
        A_MASK0 + 3'd1:       rdata_q <= mask_q[1];
        A_STAT0:              rdata_q <= stat_q[0];
        A_STAT0 + 3'd1:       rdata_q <= stat_q[1];
        default:              rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign irq_no  = !(pulse_low || level_low);
endmodule

// File: rtl/irq_gen_chk.sv
module irq_gen_chk
  import irq_gen_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned PULSE_NS = 500
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        clk_sel_i,
  input logic [W-1:0]      evt_a_i,
  input logic [W-1:0]      evt_b_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [W-1:0]      wdata_i,
  input logic              irq_no,
  input logic              cfg_level,
  input logic              cfg_auto,
  input logic [W-1:0]      stat_a,
  input logic [W-1:0]      stat_b,
  input logic [W-1:0]      mask_b
);
  logic [7:0] low_run_q;
  logic       cmd_wr, cfg_wr, stat_rd;

  assign cmd_wr  = wr_en_i && (addr_i == A_CMD) && wdata_i[CMD_CLR_BIT];
  assign cfg_wr  = wr_en_i && (addr_i == A_CFG);
  assign stat_rd = rd_en_i && (addr_i == A_STAT0 || addr_i == A_STAT0 + 3'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              low_run_q <= '0;
    else if (irq_no)          low_run_q <= '0;
    else if (low_run_q != '1) low_run_q <= low_run_q + 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_high_r1: assert (irq_no) else $error("irq active in reset");
  end

  p_pulse_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_level && !$past(cfg_level) && $rose(irq_no)) |->
      (32'(low_run_q) == pulse_cycles(clk_sel_i, PULSE_NS)));

  p_level_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_level && !irq_no && !cmd_wr && !cfg_wr && !(cfg_auto && stat_rd)) |=> !irq_no);

  p_cmd_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_level && cmd_wr && evt_a_i == '0 && evt_b_i == '0) |=>
      (irq_no && stat_a == '0 && stat_b == '0));

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_auto && !cmd_wr) |=> ((stat_a & $past(stat_a)) == $past(stat_a)));

  p_both_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_level && cfg_auto && !irq_no && rd_en_i && addr_i == A_STAT0 &&
     (stat_b & mask_b) != '0 && !wr_en_i) |=> !irq_no);
endmodule

bind irq_gen irq_gen_chk #(.W(W), .PULSE_NS(PULSE_NS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clk_sel_i (clk_sel_i),
  .evt_a_i   (evt_a_i),
  .evt_b_i   (evt_b_i),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .irq_no    (irq_no),
  .cfg_level (cfg_level_q),
  .cfg_auto  (cfg_auto_q),
  .stat_a    (stat_q[0]),
  .stat_b    (stat_q[1]),
  .mask_b    (mask_q[1])
);

// File: tb/irq_gen_bench.sv
module irq_gen_bench;
  localparam int unsigned W = 8;

  typedef struct {
    bit        is_irq;
    logic [W-1:0] exp;
    string     req;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   clk_sel;
  logic [W-1:0] evt_a, evt_b, wdata, rdata;
  logic         wr_en, rd_en, irq_n;
  logic [2:0]   addr;

  item_t q[$];
  bit    chk_req = 1'b0;
  int    n_vec = 0, n_err = 0;
  bit    done = 1'b0;

  always #5 clk = ~clk;

  irq_gen #(.W(W)) u_irq_gen (
    .clk_i(clk), .rst_ni(rst_n), .clk_sel_i(clk_sel),
    .evt_a_i(evt_a), .evt_b_i(evt_b),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_no(irq_n)
  );

  // monitor: pops one expected item per flagged negedge
  always @(negedge clk) begin
    if (chk_req) begin
      item_t it;
      logic [W-1:0] act;
      n_vec++;
      if (q.size() == 0) begin
        n_err++;
        $display("FAIL scoreboard empty act=0 exp=item");
      end else begin
        it  = q.pop_front();
        act = it.is_irq ? {{(W-1){1'b0}}, irq_n} : rdata;
        if (act !== it.exp) begin
          n_err++;
          $display("FAIL %s %s act=%0h exp=%0h", it.req,
                   it.is_irq ? "irq_no" : "rdata", act, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk_irq(input bit exp, input string req);
    item_t it;
    it.is_irq = 1'b1; it.exp = W'(exp); it.req = req;
    q.push_back(it);
    chk_req = 1'b1;
    step();
    chk_req = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [W-1:0] exp, input string req);
    item_t it;
    rd_en = 1'b1; addr = a;
    step();
    rd_en = 1'b0;
    it.is_irq = 1'b0; it.exp = exp; it.req = req;
    q.push_back(it);
    chk_req = 1'b1;
    step();
    chk_req = 1'b0;
  endtask

  task automatic fire(input logic [W-1:0] a, input logic [W-1:0] b);
    evt_a = a; evt_b = b;
    step();
    evt_a = '0; evt_b = '0;
  endtask

  initial begin
    rst_n = 1'b0; clk_sel = 2'd0; evt_a = '0; evt_b = '0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    step(); step();
    chk_irq(1'b1, "R1 in reset");
    rst_n = 1'b1;
    step();
    chk_irq(1'b1, "R1 after reset");
    rd_chk(3'd0, 8'h00, "R1 cfg");
    rd_chk(3'd4, 8'h00, "R1 stat a");
    rd_chk(3'd5, 8'h00, "R1 stat b");
    rd_chk(3'd3, 8'h00, "R1 mask b");

    // pulse style, 10 MHz -> 5 cycles
    wr(3'd2, 8'h01);
    fire(8'h01, '0);
    for (int i = 0; i < 5; i++) chk_irq(1'b0, "R4 pulse low 5");
    chk_irq(1'b1, "R4 pulse end");
    chk_irq(1'b1, "R4 idle");

    // event during pulse: follow-up after one high cycle
    fire(8'h01, '0);
    chk_irq(1'b0, "R5 first pulse");
    chk_irq(1'b0, "R5 first pulse");
    evt_a = 8'h01;
    chk_irq(1'b0, "R5 first pulse");
    evt_a = '0;
    chk_irq(1'b0, "R5 first pulse not stretched");
    chk_irq(1'b0, "R5 first pulse not stretched");
    chk_irq(1'b1, "R5 single high gap");
    for (int i = 0; i < 5; i++) chk_irq(1'b0, "R5 second pulse");
    chk_irq(1'b1, "R5 second pulse end");
    chk_irq(1'b1, "R5 no third pulse");

    rd_chk(3'd4, 8'h01, "R2 stat a set");
    rd_chk(3'd4, 8'h01, "R8 read keeps stat");

    // masked event: recorded but silent
    fire(8'h02, '0);
    for (int i = 0; i < 4; i++) chk_irq(1'b1, "R3 masked no irq");
    rd_chk(3'd4, 8'h03, "R2 masked bit recorded");

    // 20 MHz -> 10 cycles, register B
    clk_sel = 2'd3;
    wr(3'd3, 8'h80);
    fire('0, 8'h80);
    for (int i = 0; i < 10; i++) chk_irq(1'b0, "R4 pulse low 10");
    chk_irq(1'b1, "R4 pulse end 10");

    wr(3'd1, 8'h01);
    rd_chk(3'd4, 8'h00, "R7 cmd zeroes stat a");
    rd_chk(3'd5, 8'h00, "R7 cmd zeroes stat b");

    // level style, auto-clear off
    wr(3'd0, 8'h01);
    fire(8'h01, '0);
    for (int i = 0; i < 6; i++) chk_irq(1'b0, "R6 level held");
    rd_chk(3'd4, 8'h01, "R8 read no clear");
    chk_irq(1'b0, "R8 level kept after read");
    wr(3'd1, 8'h01);
    chk_irq(1'b1, "R7 cmd releases level");
    rd_chk(3'd4, 8'h00, "R7 stat cleared");

    // level style, auto-clear on, both registers pending
    wr(3'd0, 8'h03);
    fire(8'h01, 8'h80);
    chk_irq(1'b0, "R6 level set");
    rd_chk(3'd4, 8'h01, "R9 read returns content");
    chk_irq(1'b0, "R10 one read keeps level");
    rd_chk(3'd4, 8'h00, "R9 read cleared stat a");
    chk_irq(1'b0, "R10 still low");
    rd_chk(3'd5, 8'h80, "R10 read second");
    chk_irq(1'b1, "R10 both read releases");

    // single register auto-clear
    fire('0, 8'h80);
    chk_irq(1'b0, "R6 level set b");
    rd_chk(3'd5, 8'h80, "R9 read b");
    chk_irq(1'b1, "R9 auto release");
    rd_chk(3'd5, 8'h00, "R9 stat b zeroed");

    step();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule